// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel buses, called A and B. Each side has an eight-bit holding register by default. The register for the A side samples the A bus and can feed the B side. The register for the B side samples the B bus and can feed the A side. For each direction, a select input chooses what goes out: the live value on the opposite bus, or the value held in that bus's register. An active-low enable and a direction input decide which bus, if any, the block drives. With the enable high, both buses are isolated and neither is driven.

Each bus pin is modelled as three signals: an input, an output value and an output enable. An integration wrapper builds the tri-state pad from them. The block runs on a single system clock. Each register has its own capture strobe, and the register loads on the clock edge at which its strobe is first seen high. The registers keep loading whether the block is isolated or transferring. A build parameter makes both data paths invert, on the live route and on the stored route alike. The registers always hold true, uninverted data.

Top module: `dual_bus_xcvr`

## Requirements
- R1: While `rst_n` is low, both holding registers clear to zero. After reset, a stored-source select therefore yields all zeros, or all ones in an inverting build.
- R2: While `en_n` is 1, `a_oe` and `b_oe` are both 0.
- R3: While `en_n` is 0, `dir_a2b`=1 gives `b_oe`=1 and `a_oe`=0, and `dir_a2b`=0 gives `a_oe`=1 and `b_oe`=0. The two enables are never 1 together.
- R4: With `sel_a2b`=0 (live), `b_out` equals `a_in` in the same cycle, with no clock involved.
- R5: With `sel_a2b`=1 (stored), `b_out` equals the A-side register, and it does not follow changes on `a_in`.
- R6: With `sel_b2a`=0 (live), `a_out` equals `b_in` in the same cycle.
- R7: With `sel_b2a`=1 (stored), `a_out` equals the B-side register.
- R8: The A-side register loads `a_in` at a clock edge where `cap_a` is 1 and was 0 at the previous edge. At every other edge it holds, and this includes a strobe that stays high.
- R9: The B-side register loads `b_in` on a rising `cap_b` detected in the same way, and holds otherwise.
- R10: Captures happen no matter what `en_n`, `dir_a2b` and the selects are set to, including full isolation.
- R11: With `INVERT`=1, `a_out` and `b_out` are the bitwise complement of the selected source on both the live and the stored routes. The registers still keep the true data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_n | input | 1 | Active-low transfer enable |
| dir_a2b | input | 1 | 1: drive B from the A side; 0: drive A from the B side |
| sel_a2b | input | 1 | Source for B: 0 live A, 1 stored A |
| sel_b2a | input | 1 | Source for A: 0 live B, 1 stored B |
| cap_a | input | 1 | Capture strobe for the A-side register |
| cap_b | input | 1 | Capture strobe for the B-side register |
| a_in | input | WIDTH | Value seen on bus A |
| a_out | output | WIDTH | Value offered to bus A |
| a_oe | output | 1 | Drive enable for bus A |
| b_in | input | WIDTH | Value seen on bus B |
| b_out | output | WIDTH | Value offered to bus B |
| b_oe | output | 1 | Drive enable for bus B |

## Verification
Some rules are checked by assertions on every cycle. Isolation must turn off both drivers. The two drive enables must never be on together. A strobe rising edge must load the register with the bus value, and any other edge must leave it unchanged. A stored-source output must stay steady while no capture happens. Other behaviour needs the bench's scenarios to show it. Examples are that live data crosses in the same cycle, that a strobe held high does not load again, that a capture made in isolation appears later through the stored select, and that the inverting build complements the data while the register keeps it true. These are checked against a reference model in the bench, on a normal build and an inverting build driven side by side.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_e;

  typedef enum logic {
    DIR_TO_A = 1'b0,
    DIR_TO_B = 1'b1
  } dir_e;
endpackage

// File: rtl/capture_reg.sv
module capture_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strb,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             load
);
  logic             strb_q;
  logic [WIDTH-1:0] q_nxt;

  always_comb begin
    load  = strb & ~strb_q;
    q_nxt = q;
    if (load) q_nxt = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_q <= 1'b0;
      q      <= '0;
    end else begin
      strb_q <= strb;
      q      <= q_nxt;
    end
  end

  // R8 / R9: a first-seen strobe loads the bus value
  a_r8_load: assert property (@(posedge clk) disable iff (!rst_n)
    (strb && !strb_q) |=> (q == $past(din)));
  // R8 / R9: the register holds when no rising strobe is seen
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb && !strb_q) |=> $stable(q));
endmodule

// File: rtl/path_sel.sv
module path_sel #(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input  xcvr_pkg::src_e   sel,
  input  logic [WIDTH-1:0] live,
  input  logic [WIDTH-1:0] stored,
  output logic [WIDTH-1:0] dout
);
  import xcvr_pkg::*;
  logic [WIDTH-1:0] pick;

  always_comb begin
    pick = (sel == SRC_STORED) ? stored : live;
  end

  generate
    if (INVERT) begin : g_inv
      assign dout = ~pick;
    end else begin : g_thru
      assign dout = pick;
    end
  endgenerate
endmodule

// File: rtl/drive_ctrl.sv
module drive_ctrl (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en_n,
  input  xcvr_pkg::dir_e dir,
  output logic           a_oe,
  output logic           b_oe
);
  import xcvr_pkg::*;
  logic active;

  always_comb begin
    active = ~en_n;
    a_oe   = active & (dir == DIR_TO_A);
    b_oe   = active & (dir == DIR_TO_B);
  end

  // R2: isolation turns off both drivers
  a_r2_isolate: assert property (@(posedge clk) disable iff (!rst_n)
    en_n |-> (!a_oe && !b_oe));
  // R3: never both buses driven
  a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({a_oe, b_oe}) <= 1);
  // R3: enabled means exactly one bus driven
  a_r3_one_driven: assert property (@(posedge clk) disable iff (!rst_n)
    !en_n |-> $onehot0({a_oe, b_oe}) && (a_oe || b_oe));
endmodule

// File: rtl/dual_bus_xcvr.sv
module dual_bus_xcvr #(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_n,
  input  logic             dir_a2b,
  input  logic             sel_a2b,
  input  logic             sel_b2a,
  input  logic             cap_a,
  input  logic             cap_b,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe
);
  import xcvr_pkg::*;

  logic [WIDTH-1:0] reg_a, reg_b;
  logic             load_a, load_b;
  src_e             src_a2b, src_b2a;
  dir_e             dir_sel;

  always_comb begin
    src_a2b = src_e'(sel_a2b);
    src_b2a = src_e'(sel_b2a);
    dir_sel = dir_e'(dir_a2b);
  end

  capture_reg #(.WIDTH(WIDTH)) u_cap_a (
    .clk(clk), .rst_n(rst_n), .strb(cap_a), .din(a_in), .q(reg_a), .load(load_a)
  );

  capture_reg #(.WIDTH(WIDTH)) u_cap_b (
    .clk(clk), .rst_n(rst_n), .strb(cap_b), .din(b_in), .q(reg_b), .load(load_b)
  );

  path_sel #(.WIDTH(WIDTH), .INVERT(INVERT)) u_to_b (
    .sel(src_a2b), .live(a_in), .stored(reg_a), .dout(b_out)
  );

  path_sel #(.WIDTH(WIDTH), .INVERT(INVERT)) u_to_a (
    .sel(src_b2a), .live(b_in), .stored(reg_b), .dout(a_out)
  );

  drive_ctrl u_drv (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .dir(dir_sel), .a_oe(a_oe), .b_oe(b_oe)
  );

  // R5: a stored-source output on B is steady while no capture occurs
  a_r5_stored_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a2b && $past(sel_a2b) && !$past(load_a)) |-> $stable(b_out));
  // R7: a stored-source output on A is steady while no capture occurs
  a_r7_stored_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_b2a && $past(sel_b2a) && !$past(load_b)) |-> $stable(a_out));
endmodule

// File: tb/tb_dual_bus_xcvr.sv
module tb_dual_bus_xcvr;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic en_n, dir_a2b, sel_a2b, sel_b2a, cap_a, cap_b;
  logic [W-1:0] a_in, b_in;
  logic [W-1:0] a_out, b_out, ai_out, bi_out;
  logic a_oe, b_oe, ai_oe, bi_oe;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [W-1:0] m_ra, m_rb;
  logic m_pa, m_pb;

  always #2.5 clk = ~clk;

  dual_bus_xcvr #(.WIDTH(W), .INVERT(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .dir_a2b(dir_a2b),
    .sel_a2b(sel_a2b), .sel_b2a(sel_b2a), .cap_a(cap_a), .cap_b(cap_b),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  dual_bus_xcvr #(.WIDTH(W), .INVERT(1'b1)) dut_inv (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .dir_a2b(dir_a2b),
    .sel_a2b(sel_a2b), .sel_b2a(sel_b2a), .cap_a(cap_a), .cap_b(cap_b),
    .a_in(a_in), .a_out(ai_out), .a_oe(ai_oe),
    .b_in(b_in), .b_out(bi_out), .b_oe(bi_oe)
  );

  function automatic logic [W-1:0] exp_b(input logic inv);
    logic [W-1:0] v;
    v = sel_a2b ? m_ra : a_in;
    return inv ? ~v : v;
  endfunction

  function automatic logic [W-1:0] exp_a(input logic inv);
    logic [W-1:0] v;
    v = sel_b2a ? m_rb : b_in;
    return inv ? ~v : v;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string ctx);
    logic eb, ea;
    eb = !en_n && dir_a2b;
    ea = !en_n && !dir_a2b;
    chk(en_n ? "R2 b_oe" : "R3 b_oe", {7'd0, b_oe}, {7'd0, eb});
    chk(en_n ? "R2 a_oe" : "R3 a_oe", {7'd0, a_oe}, {7'd0, ea});
    chk("R3 inv b_oe", {7'd0, bi_oe}, {7'd0, eb});
    chk(sel_a2b ? {"R5 ", ctx} : {"R4 ", ctx}, b_out, exp_b(1'b0));
    chk(sel_b2a ? {"R7 ", ctx} : {"R6 ", ctx}, a_out, exp_a(1'b0));
    chk({"R11 b ", ctx}, bi_out, exp_b(1'b1));
    chk({"R11 a ", ctx}, ai_out, exp_a(1'b1));
  endtask

  // drive at negedge, check mid-low phase, then commit the model at posedge
  task automatic step(input logic en, input logic dr, input logic sab, input logic sba,
                      input logic ca, input logic cb, input logic [W-1:0] av,
                      input logic [W-1:0] bv, input string ctx);
    @(negedge clk);
    en_n = en; dir_a2b = dr; sel_a2b = sab; sel_b2a = sba;
    cap_a = ca; cap_b = cb; a_in = av; b_in = bv;
    #1;
    check_all(ctx);
    @(posedge clk);
    if (cap_a && !m_pa) m_ra = a_in;   // R8
    if (cap_b && !m_pb) m_rb = b_in;   // R9
    m_pa = cap_a;
    m_pb = cap_b;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    rst_n = 1'b0;
    en_n = 1'b1; dir_a2b = 1'b0; sel_a2b = 1'b1; sel_b2a = 1'b1;
    cap_a = 1'b0; cap_b = 1'b0; a_in = 8'h5a; b_in = 8'ha5;
    m_ra = '0; m_rb = '0; m_pa = 1'b0; m_pb = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset clears both registers
    chk("R1 b_out", b_out, 8'h00);
    chk("R1 a_out", a_out, 8'h00);
    chk("R1 inv b_out", bi_out, 8'hff);
    chk("R2 reset oe", {6'd0, a_oe, b_oe}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    // R10: capture while isolated, observe later through stored select
    step(1, 0, 1, 1, 1, 1, 8'h3c, 8'hc3, "iso capture");
    step(1, 0, 1, 1, 0, 0, 8'h00, 8'h00, "iso hold");
    step(0, 1, 1, 0, 0, 0, 8'hff, 8'h11, "R10 stored A to B");
    chk("R10 b_out", b_out, 8'h3c);
    step(0, 0, 0, 1, 0, 0, 8'h22, 8'h99, "R10 stored B to A");
    chk("R10 a_out", a_out, 8'hc3);

    // R8: strobe held high must not reload
    step(0, 1, 1, 1, 1, 0, 8'h81, 8'h00, "R8 rise");
    step(0, 1, 1, 1, 1, 0, 8'h7e, 8'h00, "R8 held");
    step(0, 1, 1, 1, 1, 0, 8'h42, 8'h00, "R8 held2");
    chk("R8 held value", b_out, 8'h81);
    // R9: same on the B side
    step(0, 0, 1, 1, 0, 1, 8'h00, 8'h18, "R9 rise");
    step(0, 0, 1, 1, 0, 1, 8'h00, 8'he7, "R9 held");
    chk("R9 held value", a_out, 8'h18);
    // R4 / R6: live paths with all-ones and all-zeros
    step(0, 1, 0, 0, 0, 0, 8'hff, 8'h00, "R4 live");
    step(0, 0, 0, 0, 0, 0, 8'h00, 8'hff, "R6 live");
    // R11: register keeps true data in the inverting build
    step(0, 1, 0, 0, 1, 0, 8'h0f, 8'h00, "R11 load");
    step(0, 1, 1, 0, 0, 0, 8'haa, 8'h00, "R11 stored");
    chk("R11 stored inv", bi_out, 8'hf0);

    for (int i = 0; i < 400; i++) begin
      step($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
           $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
           W'($urandom), W'($urandom), "random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule